// File: doc/BRIEF.md
# DMA Channel Address and Count Engine

This block keeps the transfer state of a single DMA channel. It has a base and a current copy of a 16-bit memory address, and a base and a current copy of a 16-bit word count. Each transfer strobe moves the current address one step up or down and counts the current word count down by one. The bus-cycle logic that owns the actual transfers supplies the strobes. The count is programmed with one less than the number of bytes to move. A programmed value of N therefore allows N+1 transfers, and a single programming can cover up to 65536 bytes.

A strobe that arrives while the current count is zero is the terminal count. The block then raises a one-cycle end-of-process pulse and sets a sticky terminal-count status bit. If automatic reload is enabled, it copies the base registers back into the current registers. If it is not, it masks the channel, and the channel ignores further strobes. An external end-of-process input ends the transfer through the same completion path. Software programs the block through an 8-bit write port with a register select and a low/high byte pointer. Mode decode, arbitration and bus timing are handled by neighbouring logic, which drives plain control pins into this block.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset both current registers and both base registers are 0000h, mask_out is 1, tc_status is 0 and eop_out is 0.
- R2: A write with wr_sel=0 targets the address and one with wr_sel=1 targets the count. The byte pointer starts at low after reset, toggles on every write, and returns to low when ptr_clr pulses. A low write sets bits 7:0 and a high write sets bits 15:8 of both the base and the current copy, and the result is visible on the next cycle.
- R3: An accepted strobe changes cur_addr on the next cycle. It adds one when addr_dec=0 and subtracts one when addr_dec=1, wrapping modulo 65536.
- R4: Each accepted strobe lowers cur_count by one. A programmed count of N lets N+1 strobes be accepted before completion.
- R5: A strobe accepted while cur_count is 0000h makes eop_out high for exactly the next cycle, sets tc_status, and leaves cur_count at FFFFh when automatic reload is off.
- R6: When automatic reload is off, completion sets mask_out. While mask_out is 1, strobes and eop_in have no effect on cur_addr, cur_count or eop_out.
- R7: When auto_init=1, completion reloads cur_addr and cur_count from their base copies and leaves mask_out unchanged.
- R8: On an unmasked channel, eop_in causes the same completion as terminal count (eop_out pulse, tc_status, mask or reload) without stepping the address or count.
- R9: A strobe or eop_in in the same cycle as a register write is ignored, and only the write takes effect.
- R10: Writing the high byte of the count clears tc_status. mask_wr loads mask_val into the mask unless a completion happens in the same cycle, in which case the completion wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 address, 1 count |
| wr_data | input | 8 | Write byte |
| ptr_clr | input | 1 | Return byte pointer to low byte |
| addr_dec | input | 1 | 1 = decrement address per transfer |
| auto_init | input | 1 | 1 = reload current registers at completion |
| mask_wr | input | 1 | Load mask from mask_val |
| mask_val | input | 1 | Mask value to load |
| xfer | input | 1 | One transfer done this cycle |
| eop_in | input | 1 | External end-of-process request |
| cur_addr | output | 16 | Current address |
| cur_count | output | 16 | Current word count |
| eop_out | output | 1 | One-cycle completion pulse |
| tc_status | output | 1 | Sticky terminal-count status |
| mask_out | output | 1 | Channel mask |

## Verification
The bench builds the engine with its default 8-bit byte width, which gives 16-bit address and count registers. With that width, the wrap of the address from FFFFh to 0000h in both directions can be reached directly by programming. The count rollover from 0000h to FFFFh, which marks terminal count, can be reached with only a couple of strobes. Small programmed counts keep the automatic-reload and mask paths within a handful of cycles each.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  typedef enum logic {
    SEL_ADDR  = 1'b0,
    SEL_COUNT = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/dma_byte_ptr.sv
module dma_byte_ptr (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic adv,
  output logic hi_sel
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   hi_sel <= 1'b0;
    else if (clr) hi_sel <= 1'b0;
    else if (adv) hi_sel <= ~hi_sel;
  end
endmodule

// File: rtl/dma_shadow_reg.sv
// Base/current register pair with byte-wise load, step and reload.
module dma_shadow_reg #(
  parameter int BYTE_W = 8,
  localparam int W     = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic              step,
  input  logic              step_down,
  input  logic              reload,
  output logic [W-1:0]      base_q,
  output logic [W-1:0]      cur_q
);
  logic [W-1:0] stepped;

  always_comb begin
    if (step_down) stepped = cur_q - W'(1);
    else           stepped = cur_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cur_q  <= '0;
    end else if (wr_lo) begin
      base_q[BYTE_W-1:0] <= wr_byte;
      cur_q[BYTE_W-1:0]  <= wr_byte;
    end else if (wr_hi) begin
      base_q[W-1:BYTE_W] <= wr_byte;
      cur_q[W-1:BYTE_W]  <= wr_byte;
    end else if (reload) begin
      cur_q <= base_q;
    end else if (step) begin
      cur_q <= stepped;
    end
  end
endmodule

// File: rtl/dma_done_ctrl.sv
// Completion logic: accept gating, end-of-process pulse, status and mask.
module dma_done_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic xfer,
  input  logic eop_in,
  input  logic wr_any,
  input  logic count_zero,
  input  logic auto_init,
  input  logic mask_wr,
  input  logic mask_val,
  input  logic tc_clr,
  output logic step_go,
  output logic reload_go,
  output logic eop_q,
  output logic tc_q,
  output logic mask_q
);
  logic active;
  logic done;

  always_comb begin
    active    = !mask_q && !wr_any;
    step_go   = active && xfer;
    done      = active && ((xfer && count_zero) || eop_in);
    reload_go = done && auto_init;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eop_q  <= 1'b0;
      tc_q   <= 1'b0;
      mask_q <= 1'b1;
    end else begin
      eop_q <= done;
      if (done)        tc_q <= 1'b1;
      else if (tc_clr) tc_q <= 1'b0;
      if (done && !auto_init) mask_q <= 1'b1;
      else if (mask_wr)       mask_q <= mask_val;
    end
  end
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine #(
  parameter int BYTE_W = 8,
  localparam int W     = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              ptr_clr,
  input  logic              addr_dec,
  input  logic              auto_init,
  input  logic              mask_wr,
  input  logic              mask_val,
  input  logic              xfer,
  input  logic              eop_in,
  output logic [W-1:0]      cur_addr,
  output logic [W-1:0]      cur_count,
  output logic              eop_out,
  output logic              tc_status,
  output logic              mask_out
);
  import dma_chan_pkg::*;

  reg_sel_e     sel;
  logic         hi_sel;
  logic         step_go, reload_go;
  logic         a_lo, a_hi, c_lo, c_hi;
  logic [W-1:0] addr_base, cnt_base;

  always_comb begin
    sel  = reg_sel_e'(wr_sel);
    a_lo = wr_en && (sel == SEL_ADDR)  && !hi_sel;
    a_hi = wr_en && (sel == SEL_ADDR)  &&  hi_sel;
    c_lo = wr_en && (sel == SEL_COUNT) && !hi_sel;
    c_hi = wr_en && (sel == SEL_COUNT) &&  hi_sel;
  end

  dma_byte_ptr u_ptr (
    .clk(clk), .rst_n(rst_n), .clr(ptr_clr), .adv(wr_en), .hi_sel(hi_sel)
  );

  dma_shadow_reg #(.BYTE_W(BYTE_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .wr_lo(a_lo), .wr_hi(a_hi), .wr_byte(wr_data),
    .step(step_go), .step_down(addr_dec), .reload(reload_go),
    .base_q(addr_base), .cur_q(cur_addr)
  );

  dma_shadow_reg #(.BYTE_W(BYTE_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .wr_lo(c_lo), .wr_hi(c_hi), .wr_byte(wr_data),
    .step(step_go), .step_down(1'b1), .reload(reload_go),
    .base_q(cnt_base), .cur_q(cur_count)
  );

  dma_done_ctrl u_done (
    .clk(clk), .rst_n(rst_n), .xfer(xfer), .eop_in(eop_in), .wr_any(wr_en),
    .count_zero(cur_count == '0), .auto_init(auto_init),
    .mask_wr(mask_wr), .mask_val(mask_val), .tc_clr(c_hi),
    .step_go(step_go), .reload_go(reload_go),
    .eop_q(eop_out), .tc_q(tc_status), .mask_q(mask_out)
  );
endmodule

// File: rtl/dma_chan_engine_chk.sv
module dma_chan_engine_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic         addr_dec,
  input logic         auto_init,
  input logic         xfer,
  input logic         eop_in,
  input logic [W-1:0] cur_addr,
  input logic [W-1:0] cur_count,
  input logic [W-1:0] addr_base,
  input logic [W-1:0] cnt_base,
  input logic         eop_out,
  input logic         tc_status,
  input logic         mask_out
);
  // R3
  inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !mask_out && !wr_en && !eop_in && !addr_dec && cur_count != '0)
      |=> cur_addr == $past(cur_addr) + W'(1));
  // R4
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !mask_out && !wr_en && !eop_in && cur_count != '0)
      |=> (cur_count == $past(cur_count) - W'(1)) && !eop_out);
  // R5
  term_eop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !mask_out && !wr_en && cur_count == '0) |=> eop_out && tc_status);
  // R6
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_out && !wr_en)
      |=> $stable(cur_addr) && $stable(cur_count) && !eop_out);
  // R7
  auto_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eop_out && $past(auto_init))
      |-> cur_addr == addr_base && cur_count == cnt_base);
  // R9
  wr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !mask_out) |=> !eop_out);
endmodule

bind dma_chan_engine dma_chan_engine_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr_dec(addr_dec),
  .auto_init(auto_init), .xfer(xfer), .eop_in(eop_in),
  .cur_addr(cur_addr), .cur_count(cur_count),
  .addr_base(addr_base), .cnt_base(cnt_base),
  .eop_out(eop_out), .tc_status(tc_status), .mask_out(mask_out)
);

// File: tb/dma_chan_engine_tb_top.sv
module dma_chan_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 0, wr_sel = 0, ptr_clr = 0, addr_dec = 0, auto_init = 0;
  logic        mask_wr = 0, mask_val = 0, xfer = 0, eop_in = 0;
  logic [7:0]  wr_data = '0;
  logic [15:0] cur_addr, cur_count;
  logic        eop_out, tc_status, mask_out;
  int          total = 0, bad = 0;

  always #4 clk = ~clk;

  dma_chan_engine dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ptr_clr(ptr_clr), .addr_dec(addr_dec), .auto_init(auto_init),
    .mask_wr(mask_wr), .mask_val(mask_val), .xfer(xfer), .eop_in(eop_in),
    .cur_addr(cur_addr), .cur_count(cur_count), .eop_out(eop_out),
    .tc_status(tc_status), .mask_out(mask_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_byte(input logic sel, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic prog(input logic sel, input logic [15:0] v);
    wr_byte(sel, v[7:0]);
    wr_byte(sel, v[15:8]);
  endtask

  task automatic set_mask(input logic v);
    @(negedge clk); mask_wr = 1; mask_val = v;
    @(negedge clk); mask_wr = 0;
  endtask

  task automatic strobe();
    @(negedge clk); xfer = 1;
    @(negedge clk); xfer = 0;
  endtask

  task automatic t_reset();
    chk("R1 addr", cur_addr, 16'h0000);
    chk("R1 count", cur_count, 16'h0000);
    chk("R1 mask", mask_out, 1);
    chk("R1 tc", tc_status, 0);
    chk("R1 eop", eop_out, 0);
  endtask

  task automatic t_inc_terminal();
    addr_dec = 0; auto_init = 0;
    prog(0, 16'h1234); prog(1, 16'h0002); set_mask(0);
    chk("R2 addr load", cur_addr, 16'h1234);
    chk("R2 count load", cur_count, 16'h0002);
    strobe(); chk("R3 inc", cur_addr, 16'h1235); chk("R4 cnt", cur_count, 16'h0001);
    strobe(); chk("R3 inc2", cur_addr, 16'h1236); chk("R4 cnt2", cur_count, 16'h0000);
    chk("R4 no early eop", eop_out, 0);
    strobe();
    chk("R5 eop", eop_out, 1); chk("R5 tc", tc_status, 1);
    chk("R5 count wrap", cur_count, 16'hFFFF); chk("R6 mask set", mask_out, 1);
    @(negedge clk); chk("R5 eop single", eop_out, 0);
    strobe(); chk("R6 masked addr", cur_addr, 16'h1237);
    chk("R6 masked cnt", cur_count, 16'hFFFF);
    @(negedge clk); eop_in = 1; @(negedge clk); eop_in = 0;
    chk("R6 masked eop_in", eop_out, 0);
  endtask

  task automatic t_dec();
    addr_dec = 1; auto_init = 0;
    prog(0, 16'h0001); prog(1, 16'h0001);
    chk("R10 tc clear", tc_status, 0);
    set_mask(0);
    strobe(); chk("R3 dec", cur_addr, 16'h0000);
    strobe(); chk("R3 dec wrap", cur_addr, 16'hFFFF); chk("R5 eop dec", eop_out, 1);
    addr_dec = 0;
  endtask

  task automatic t_auto();
    auto_init = 1;
    prog(0, 16'h8000); prog(1, 16'h0001); set_mask(0);
    strobe(); chk("R7 step", cur_addr, 16'h8001);
    strobe();
    chk("R7 reload addr", cur_addr, 16'h8000); chk("R7 reload cnt", cur_count, 16'h0001);
    chk("R7 mask kept", mask_out, 0); chk("R7 eop", eop_out, 1);
    strobe(); chk("R7 runs on", cur_addr, 16'h8001);
    auto_init = 0;
  endtask

  task automatic t_eop_in();
    prog(0, 16'h0100); prog(1, 16'h0005); set_mask(0);
    @(negedge clk); eop_in = 1; @(negedge clk); eop_in = 0;
    chk("R8 eop", eop_out, 1); chk("R8 mask", mask_out, 1);
    chk("R8 tc", tc_status, 1);
    chk("R8 no step cnt", cur_count, 16'h0005); chk("R8 no step addr", cur_addr, 16'h0100);
  endtask

  task automatic t_ptr_clr();
    wr_byte(0, 8'hAA);
    @(negedge clk); ptr_clr = 1; @(negedge clk); ptr_clr = 0;
    prog(0, 16'h4321);
    chk("R2 ptr clear", cur_addr, 16'h4321);
  endtask

  task automatic t_priority();
    prog(1, 16'h0010); set_mask(0);
    @(negedge clk); wr_en = 1; wr_sel = 1; wr_data = 8'h07; xfer = 1;
    @(negedge clk); wr_en = 0; xfer = 0;
    chk("R9 write wins cnt", cur_count, 16'h0007);
    chk("R9 addr held", cur_addr, 16'h4321);
    wr_byte(1, 8'h00);
    @(negedge clk); wr_en = 1; wr_sel = 0; wr_data = 8'h11; eop_in = 1;
    @(negedge clk); wr_en = 0; eop_in = 0;
    chk("R9 eop_in blocked", eop_out, 0);
    chk("R9 mask kept", mask_out, 0);
    wr_byte(0, 8'h43);
  endtask

  task automatic t_wrap();
    prog(0, 16'hFFFF); prog(1, 16'h0004); set_mask(0);
    strobe(); chk("R3 inc wrap", cur_addr, 16'h0000);
    chk("R4 cnt", cur_count, 16'h0003);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_inc_terminal();
    t_dec();
    t_auto();
    t_eop_in();
    t_ptr_clr();
    t_priority();
    t_wrap();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule